// File: doc/BRIEF.md
# Load/Store Sizing and Register-Group Unit

This unit performs the data-movement half of load and store operations. It sits between a register file and a 32-bit memory data port. A request carries a byte address, a 4-bit operation code, a load/store select and a starting register number. A load fetches one to four 32-bit words and writes them into successive registers. Byte and half-word loads pick their lane from the low address bits and widen the value to 32 bits. Unsigned forms are zero-extended and signed forms are sign-extended. A store reads successive registers and sends them to memory. Narrow stores send only the low byte or half-word of the register, under byte enables for the addressed lanes.

Multi-register transfers run one 32-bit beat per cycle. The lowest memory word goes to or from the lowest-numbered register. The starting register of a group must be aligned to the group. A request that breaks this rule, or that uses a reserved code, raises a fault and touches nothing. Address generation, caching and arbitration are handled elsewhere. The register-file read and the memory read are combinational responses from the attached blocks.

Top module: `lsu_group_unit`

## Requirements
- R1: Operation codes are 0 word, 1 unsigned byte, 2 unsigned half-word, 3 signed byte, 4 signed half-word, 5 long (2 words), 6 triple (3 words), 7 quad (4 words). `req_store`=1 selects a store and 0 a load. A word load copies the addressed memory word into one register, and a word store copies one register into the word with all four byte enables set.
- R2: Unsigned byte loads take byte lane `addr[1:0]`, and unsigned half-word loads take the upper half when `addr[1]`=1 and the lower half otherwise. Both are zero-extended to 32 bits.
- R3: Signed byte and signed half-word loads select the lane the same way as R2 and sign-extend to 32 bits.
- R4: A long transfer moves 2 words between consecutive memory words and registers r, r+1, with the lowest address paired with r. r must be even. Every beat of a transfer longer than one word has all byte enables set.
- R5: Triple and quad transfers move 3 and 4 words between consecutive memory words and registers r, r+1, r+2, r+3 in the same pairing. r must be a multiple of 4.
- R6: A request whose starting register breaks R4 or R5 raises `fault` for exactly one cycle, in the cycle after the request. It writes no register and no memory, and `busy` stays low.
- R7: A byte store sets only enable bit `addr[1:0]` and a half-word store sets only enables 1:0 or 3:2 (by `addr[1]`). The low byte or half-word of the register is replicated on the data bus, and the other bytes of the memory word keep their value.
- R8: An accepted request raises `busy` in the next cycle. `busy` stays high for one cycle per beat. `done` pulses for one cycle right after the last beat, with `busy` low. Requests arriving while `busy` is high are ignored.
- R9: Operation codes 8 to 15 are reserved and are handled as in R6 for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_store | input | 1 | 1 = store, 0 = load |
| req_op | input | 4 | Operation code (R1) |
| req_addr | input | ADDR_W | Byte address of the first word or of the narrow item |
| req_reg | input | REG_AW | Starting register number |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle pulse for misaligned or reserved request |
| mem_valid | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, combinational response to mem_addr |
| rf_rd_addr | output | REG_AW | Register read index |
| rf_rd_data | input | 32 | Register read data, combinational |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_addr | output | REG_AW | Register write index |
| rf_wr_data | output | 32 | Register write data |

## Verification
The assertions assume that the memory and the register file answer combinationally in the same cycle as the address, and that the caller drops `req_valid` after its request is taken. They also assume that the starting register plus the group size stays within the register file, which the alignment rule ensures for the default size. The bench uses a memory model with combinational reads and writes at the clock edge. It drives each request for a single cycle from the falling edge, and drives a deliberate intrusion only during a busy window to exercise the ignore rule. Addresses stay inside the 64-word memory model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int          MAX_BEATS = 4;
  localparam int          BEAT_W    = $clog2(MAX_BEATS);

  localparam logic [3:0]  OP_WORD   = 4'd0;
  localparam logic [3:0]  OP_UBYTE  = 4'd1;
  localparam logic [3:0]  OP_UHALF  = 4'd2;
  localparam logic [3:0]  OP_SBYTE  = 4'd3;
  localparam logic [3:0]  OP_SHALF  = 4'd4;
  localparam logic [3:0]  OP_LONG   = 4'd5;
  localparam logic [3:0]  OP_TRIPLE = 4'd6;
  localparam logic [3:0]  OP_QUAD   = 4'd7;

  // index of the final beat for a legal code
  function automatic logic [BEAT_W-1:0] last_beat_of(input logic [3:0] op);
    case (op)
      OP_LONG:   last_beat_of = BEAT_W'(1);
      OP_TRIPLE: last_beat_of = BEAT_W'(2);
      OP_QUAD:   last_beat_of = BEAT_W'(3);
      default:   last_beat_of = '0;
    endcase
  endfunction

  // defined code and register-group alignment
  function automatic logic request_ok(input logic [3:0] op, input logic [1:0] reg_lo);
    case (op)
      OP_WORD, OP_UBYTE, OP_UHALF, OP_SBYTE, OP_SHALF: request_ok = 1'b1;
      OP_LONG:                                         request_ok = ~reg_lo[0];
      OP_TRIPLE, OP_QUAD:                              request_ok = (reg_lo == 2'b00);
      default:                                         request_ok = 1'b0;
    endcase
  endfunction

  function automatic logic is_byte(input logic [3:0] op);
    is_byte = (op == OP_UBYTE) || (op == OP_SBYTE);
  endfunction

  function automatic logic is_half(input logic [3:0] op);
    is_half = (op == OP_UHALF) || (op == OP_SHALF);
  endfunction

  // lane pick and width extension of a fetched word
  function automatic logic [31:0] widen(input logic [3:0] op, input logic [31:0] w,
                                        input logic [1:0] alo);
    logic [31:0] sh;
    logic [7:0]  b;
    logic [15:0] h;
    sh = w >> {alo, 3'b000};
    b  = sh[7:0];
    h  = alo[1] ? w[31:16] : w[15:0];
    case (op)
      OP_UBYTE: widen = {24'd0, b};
      OP_SBYTE: widen = {{24{b[7]}}, b};
      OP_UHALF: widen = {16'd0, h};
      OP_SHALF: widen = {{16{h[15]}}, h};
      default:  widen = w;
    endcase
  endfunction

  function automatic logic [3:0] lanes(input logic [3:0] op, input logic [1:0] alo);
    if (is_byte(op))      lanes = 4'b0001 << alo;
    else if (is_half(op)) lanes = alo[1] ? 4'b1100 : 4'b0011;
    else                  lanes = 4'b1111;
  endfunction

  function automatic logic [31:0] spread(input logic [3:0] op, input logic [31:0] d);
    if (is_byte(op))      spread = {4{d[7:0]}};
    else if (is_half(op)) spread = {2{d[15:0]}};
    else                  spread = d;
  endfunction

endpackage

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [3:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [REG_AW-1:0]    req_reg,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic [BEAT_W-1:0]    beat,
  output logic                 q_store,
  output logic [3:0]           q_op,
  output logic [ADDR_W-3:0]    q_word,
  output logic [1:0]           q_alo,
  output logic [REG_AW-1:0]    q_reg
);

  logic              accept;
  logic              legal;
  logic              final_beat;
  logic [BEAT_W-1:0] q_last;

  assign accept     = req_valid && !busy;
  assign legal      = request_ok(req_op, req_reg[1:0]);
  assign final_beat = busy && (beat == q_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      beat    <= '0;
      q_last  <= '0;
      q_store <= 1'b0;
      q_op    <= '0;
      q_word  <= '0;
      q_alo   <= '0;
      q_reg   <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (accept) begin
        if (legal) begin
          busy    <= 1'b1;
          beat    <= '0;
          q_last  <= last_beat_of(req_op);
          q_store <= req_store;
          q_op    <= req_op;
          q_word  <= req_addr[ADDR_W-1:2];
          q_alo   <= req_addr[1:0];
          q_reg   <= req_reg;
        end else begin
          fault <= 1'b1;
        end
      end else if (busy) begin
        if (final_beat) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  assert_fault_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_beat_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (beat <= q_last));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !final_beat) |=> busy);

endmodule

// File: rtl/lsu_dp.sv
module lsu_dp
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic [BEAT_W-1:0]    beat,
  input  logic                 q_store,
  input  logic [3:0]           q_op,
  input  logic [ADDR_W-3:0]    q_word,
  input  logic [1:0]           q_alo,
  input  logic [REG_AW-1:0]    q_reg,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [3:0]           mem_be,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  output logic [REG_AW-1:0]    rf_rd_addr,
  input  logic [31:0]          rf_rd_data,
  output logic                 rf_wr_en,
  output logic [REG_AW-1:0]    rf_wr_addr,
  output logic [31:0]          rf_wr_data
);

  logic [REG_AW-1:0] cur_reg;
  logic [ADDR_W-3:0] cur_word;
  logic              narrow_byte;
  logic              narrow_half;
  logic              multi;

  assign cur_reg     = q_reg + REG_AW'(beat);
  assign cur_word    = q_word + (ADDR_W-2)'(beat);
  assign narrow_byte = is_byte(q_op);
  assign narrow_half = is_half(q_op);
  assign multi       = (last_beat_of(q_op) != '0);

  assign mem_valid   = busy;
  assign mem_we      = busy && q_store;
  assign mem_addr    = {cur_word, 2'b00};
  assign mem_be      = q_store ? lanes(q_op, q_alo) : 4'b0000;
  assign mem_wdata   = spread(q_op, rf_rd_data);

  assign rf_rd_addr  = cur_reg;
  assign rf_wr_en    = busy && !q_store;
  assign rf_wr_addr  = cur_reg;
  assign rf_wr_data  = widen(q_op, mem_rdata, q_alo);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !mem_we && !rf_wr_en));

  assert_byte_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && narrow_byte) |-> ($countones(mem_be) == 1));

  assert_half_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && narrow_half) |-> ($countones(mem_be) == 2 && (mem_be[0] == mem_be[1])));

  assert_wide_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && multi) |-> (mem_be == 4'b1111));

  assert_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(mem_we && !busy)) |->
      (rf_rd_addr == $past(rf_rd_addr) + 1'b1));

endmodule

// File: rtl/lsu_group_unit.sv
module lsu_group_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [3:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [REG_AW-1:0]    req_reg,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [3:0]           mem_be,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  output logic [REG_AW-1:0]    rf_rd_addr,
  input  logic [31:0]          rf_rd_data,
  output logic                 rf_wr_en,
  output logic [REG_AW-1:0]    rf_wr_addr,
  output logic [31:0]          rf_wr_data
);

  logic [BEAT_W-1:0] beat;
  logic              q_store;
  logic [3:0]        q_op;
  logic [ADDR_W-3:0] q_word;
  logic [1:0]        q_alo;
  logic [REG_AW-1:0] q_reg;

  lsu_seq #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg),
    .busy(busy), .done(done), .fault(fault), .beat(beat),
    .q_store(q_store), .q_op(q_op), .q_word(q_word), .q_alo(q_alo), .q_reg(q_reg)
  );

  lsu_dp #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .beat(beat),
    .q_store(q_store), .q_op(q_op), .q_word(q_word), .q_alo(q_alo), .q_reg(q_reg),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data)
  );

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && done));

endmodule

// File: tb/lsu_group_unit_bench.sv
module lsu_group_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [3:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_reg = '0;
  logic        busy, done, fault;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [4:0]  rf_rd_addr, rf_wr_addr;
  logic [31:0] rf_rd_data, rf_wr_data;
  logic        rf_wr_en;

  always #2.5 clk = ~clk;

  lsu_group_unit u_lsu_group_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg),
    .busy(busy), .done(done), .fault(fault),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data)
  );

  // attached memory and register file
  logic [31:0] mem [64];
  logic [31:0] rf  [32];
  logic [31:0] exp_mem [64];
  logic [31:0] exp_rf  [32];

  assign mem_rdata  = mem[mem_addr[7:2]];
  assign rf_rd_data = rf[rf_rd_addr];

  always @(posedge clk) begin
    if (mem_valid && mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[mem_addr[7:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
    if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
  end

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit armed  = 0;

  // behavioural timing model: remaining beats, pulses
  int m_left  = 0;
  bit m_done  = 0;
  bit m_fault = 0;

  function automatic int beats_for(input int op);
    if (op < 5) return 1;
    if (op < 8) return op - 3;
    return 0;
  endfunction

  function automatic bit allowed(input int op, input int r);
    int n;
    n = beats_for(op);
    if (n == 0) return 0;
    if (n == 1) return 1;
    if (n == 2) return (r % 2) == 0;
    return (r % 4) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left <= 0; m_done <= 0; m_fault <= 0;
    end else begin
      m_done  <= 0;
      m_fault <= 0;
      if (m_left > 0) begin
        m_left <= m_left - 1;
        if (m_left == 1) m_done <= 1;
      end else if (req_valid) begin
        if (allowed(req_op, req_reg)) m_left <= beats_for(req_op);
        else m_fault <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (busy !== (m_left > 0) || done !== m_done) begin
        fails++;
        $display("FAIL R8 busy/done: actual %b/%b expected %b/%b", busy, done, m_left > 0, m_done);
      end
      checks++;
      if (fault !== m_fault) begin
        fails++;
        $display("FAIL R6 / R9 fault: actual %b expected %b", fault, m_fault);
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
      end
    end
  end

  // expected effect of one request, written from the requirements
  task automatic predict(input bit st, input int op, input int addr, input int r);
    int n, wi, lane;
    logic [31:0] v, x;
    if (!allowed(op, r)) return;
    n  = beats_for(op);
    wi = (addr / 4) % 64;
    lane = addr % 4;
    if (!st) begin
      for (int k = 0; k < n; k++) begin
        v = exp_mem[(wi + k) % 64];
        case (op)
          1: x = (v >> (8 * lane)) & 32'hFF;
          3: begin x = (v >> (8 * lane)) & 32'hFF; if (x[7]) x = x | 32'hFFFF_FF00; end
          2: x = (v >> (16 * (lane / 2))) & 32'hFFFF;
          4: begin x = (v >> (16 * (lane / 2))) & 32'hFFFF; if (x[15]) x = x | 32'hFFFF_0000; end
          default: x = v;
        endcase
        exp_rf[r + k] = x;
      end
    end else begin
      for (int k = 0; k < n; k++) begin
        v = exp_mem[(wi + k) % 64];
        x = exp_rf[r + k];
        if (op == 1 || op == 3) v[8 * lane +: 8] = x[7:0];
        else if (op == 2 || op == 4) v[16 * (lane / 2) +: 16] = x[15:0];
        else v = x;
        exp_mem[(wi + k) % 64] = v;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    for (int i = 0; i < 32; i++)
      if (rf[i] !== exp_rf[i]) begin
        fails++;
        $display("FAIL %s reg %0d: actual %h expected %h", tag, i, rf[i], exp_rf[i]);
      end
    checks++;
    for (int i = 0; i < 64; i++)
      if (mem[i] !== exp_mem[i]) begin
        fails++;
        $display("FAIL %s mem word %0d: actual %h expected %h", tag, i, mem[i], exp_mem[i]);
      end
  endtask

  task automatic run(input string tag, input bit st, input int op, input int addr,
                     input int r, input bit intrude);
    predict(st, op, addr, r);
    @(negedge clk);
    req_valid = 1; req_store = st; req_op = 4'(op); req_addr = 32'(addr); req_reg = 5'(r);
    @(negedge clk);
    req_valid = 0;
    if (intrude) begin
      // a request while busy must leave every register and word alone
      req_valid = 1; req_store = 0; req_op = 4'd0; req_addr = 32'h0; req_reg = 5'd31;
      @(negedge clk);
      req_valid = 0;
    end
    while (m_left != 0) @(negedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h8A5C_3E71 ^ (i * 32'h0101_0F0F) ^ ((i % 3) == 0 ? 32'h0080_8000 : 32'h0);
      exp_mem[i] = mem[i];
    end
    for (int i = 0; i < 32; i++) begin
      rf[i] = 32'hC3D2_E1F0 + i * 32'h1111_0203;
      exp_rf[i] = rf[i];
    end
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 0 || done !== 0 || fault !== 0 || mem_valid !== 0 || rf_wr_en !== 0) begin
      fails++;
      $display("FAIL R8 reset outputs: actual %b%b%b%b%b expected 00000",
               busy, done, fault, mem_valid, rf_wr_en);
    end
    rst_n = 1;
    armed = 1;

    run("R1 word load",       0, 0, 32'h10, 5, 0);
    run("R1 word store",      1, 0, 32'h40, 5, 0);
    run("R2 ubyte lane1",     0, 1, 32'h21, 9, 0);
    run("R2 ubyte lane3",     0, 1, 32'h0F, 10, 0);
    run("R2 uhalf upper",     0, 2, 32'h22, 11, 0);
    run("R3 sbyte lane2",     0, 3, 32'h06, 13, 0);
    run("R3 sbyte lane0",     0, 3, 32'h18, 14, 0);
    run("R3 shalf upper",     0, 4, 32'h2E, 15, 0);
    run("R3 shalf lower",     0, 4, 32'h0C, 17, 0);
    run("R4 long load",       0, 5, 32'h30, 6, 0);
    run("R4 long store",      1, 5, 32'h80, 6, 0);
    run("R5 triple load",     0, 6, 32'h50, 8, 0);
    run("R5 quad load",       0, 7, 32'h60, 12, 0);
    run("R5 quad store",      1, 7, 32'hC0, 12, 0);
    run("R5 triple store",    1, 6, 32'hE0, 24, 0);
    run("R6 long odd reg",    0, 5, 32'h70, 7, 0);
    run("R6 quad reg 10",     0, 7, 32'h70, 10, 0);
    run("R6 triple store r2", 1, 6, 32'h90, 2, 0);
    run("R7 byte store",      1, 1, 32'h41, 9, 0);
    run("R7 sbyte store",     1, 3, 32'h47, 13, 0);
    run("R7 half store up",   1, 2, 32'h46, 15, 0);
    run("R7 half store low",  1, 4, 32'hA4, 17, 0);
    run("R8 ignore busy",     0, 7, 32'hB0, 20, 1);
    run("R9 reserved load",   0, 9, 32'h10, 0, 0);
    run("R9 reserved store",  1, 15, 32'h10, 4, 0);
    summary();
  end

endmodule